// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block produces the instruction fetch address for a small 8-bit controller with a 2048-word program space. It holds an 11-bit program counter and a two-entry return stack. Each cycle the counter holds, steps by one, steps by two over a skipped instruction, or loads a new target. A new target comes from an ALU write to the counter register, from a short or long jump or call, or from the stack on a return. The counter is updated from decoded control strobes, so the instruction decoder outside the block decides which transfer happens. This block only forms the address.

Short transfers and ALU writes reach only part of the space. They take the two upper address bits from a page-select field that the status register provides. Page value p selects the 512-word range starting at p × 0x200. Long transfers carry the full 11-bit address. The low byte of the counter is also output, so it can be read as a register.

Top module: `paged_pc_unit`

## Requirements
- R1: While reset is low, the counter holds 0x7FF. After reset both stack entries hold 0x000 and the stack is empty, so a return with no call before it loads 0x000.
- R2: When `adv` is high and no other strobe is active, the counter advances by one and wraps from 0x7FF to 0x000. When every strobe and `adv` are low, the counter holds its value.
- R3: When `skip` is high, the counter advances by two, modulo 2048.
- R4: An ALU write loads {page_sel, 0, alu_data}: bits 7..0 from the ALU result, bit 8 cleared, bits 10..9 from the page field.
- R5: A short jump loads {page_sel, imm_field[8:0]}.
- R6: A short call loads {page_sel, 0, imm_field[7:0]} and pushes the current counter plus one.
- R7: A long jump loads imm_field[10:0]. A long call does the same and also pushes the current counter plus one.
- R8: A return pops the most recent pushed address into all 11 counter bits, in last-in first-out order.
- R9: A push onto a stack that already holds two entries discards the older entry.
- R10: A return from an empty stack loads the address that the previous pop returned, and the stack contents do not change.
- R11: `pc_low` always equals bits 7..0 of `fetch_addr`.
- R12: When several strobes are active in one cycle, only the one with the highest priority takes effect. The order from highest to lowest is: return, long call, long jump, short call, short jump, ALU write, skip, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Step to the next sequential instruction |
| skip | input | 1 | Step by two (skip taken) |
| alu_wr | input | 1 | ALU writes the counter register |
| alu_data | input | 8 | ALU result for a counter write |
| jmp_short | input | 1 | Short jump within the page |
| call_short | input | 1 | Short call within the page |
| jmp_long | input | 1 | Long jump, full address |
| call_long | input | 1 | Long call, full address |
| ret | input | 1 | Return, pop the stack |
| imm_field | input | 11 | Address field of the instruction word |
| page_sel | input | 2 | Page-select bits from status |
| fetch_addr | output | 11 | Program counter / fetch address |
| pc_low | output | 8 | Low byte of the counter for register reads |

## Verification
The assertions that check each load source assume that only that strobe is active in the cycle, or that no strobe with higher priority is active. They also assume the page and immediate inputs are stable during the cycle in which they are sampled. The stimulus table usually drives one strobe per cycle. Its few overlapping rows are written as priority cases, and the properties exclude those cases through their antecedents. The return-after-call property expects a return in the cycle right after the call, and the bench produces that pattern where it drives a long call followed by a return.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PC_AW = 11;
    localparam int PC_DW = 8;

    typedef enum logic [3:0] {
        SRC_HOLD,
        SRC_INC,
        SRC_SKIP,
        SRC_ALU,
        SRC_JMP_S,
        SRC_CALL_S,
        SRC_JMP_L,
        SRC_CALL_L,
        SRC_RET
    } pc_src_e;
endpackage

// File: rtl/pcs_src_sel.sv
module pcs_src_sel
    import pcs_pkg::*;
(
    input  logic    adv,
    input  logic    skip,
    input  logic    alu_wr,
    input  logic    jmp_short,
    input  logic    call_short,
    input  logic    jmp_long,
    input  logic    call_long,
    input  logic    ret,
    output pc_src_e src
);
    // fixed priority: return first, plain advance last
    always_comb begin
        if (ret)             src = SRC_RET;
        else if (call_long)  src = SRC_CALL_L;
        else if (jmp_long)   src = SRC_JMP_L;
        else if (call_short) src = SRC_CALL_S;
        else if (jmp_short)  src = SRC_JMP_S;
        else if (alu_wr)     src = SRC_ALU;
        else if (skip)       src = SRC_SKIP;
        else if (adv)        src = SRC_INC;
        else                 src = SRC_HOLD;
    end
endmodule

// File: rtl/pcs_addr_mux.sv
module pcs_addr_mux
    import pcs_pkg::*;
#(
    parameter  int AW = PC_AW,
    parameter  int DW = PC_DW,
    localparam int PW = AW - DW - 1,
    localparam int SJ = DW + 1
) (
    input  pc_src_e        src,
    input  logic [AW-1:0]  pc_cur,
    input  logic [AW-1:0]  stk_top,
    input  logic [AW-1:0]  imm_field,
    input  logic [DW-1:0]  alu_data,
    input  logic [PW-1:0]  page_sel,
    output logic [AW-1:0]  pc_nxt
);
    logic [AW-1:0] inc1;
    logic [AW-1:0] inc2;
    logic [AW-1:0] paged_byte_imm;
    logic [AW-1:0] paged_byte_alu;
    logic [AW-1:0] paged_short_jmp;

    always_comb begin
        inc1            = pc_cur + AW'(1);
        inc2            = pc_cur + AW'(2);
        // bit DW is forced low for byte-wide targets
        paged_byte_imm  = {page_sel, 1'b0, imm_field[DW-1:0]};
        paged_byte_alu  = {page_sel, 1'b0, alu_data};
        paged_short_jmp = {page_sel, imm_field[SJ-1:0]};

        unique case (src)
            SRC_INC:    pc_nxt = inc1;
            SRC_SKIP:   pc_nxt = inc2;
            SRC_ALU:    pc_nxt = paged_byte_alu;
            SRC_JMP_S:  pc_nxt = paged_short_jmp;
            SRC_CALL_S: pc_nxt = paged_byte_imm;
            SRC_JMP_L,
            SRC_CALL_L: pc_nxt = imm_field;
            SRC_RET:    pc_nxt = stk_top;
            default:    pc_nxt = pc_cur;
        endcase
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
    import pcs_pkg::*;
#(
    parameter  int AW    = PC_AW,
    localparam int DEPTH = 2,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top_val
);
    typedef struct packed {
        logic [AW-1:0] top;
        logic [AW-1:0] bot;
        logic [CW-1:0] cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            // the older entry falls off when full
            stk_d.top = push_val;
            stk_d.bot = stk_q.top;
            if (stk_q.cnt != CW'(DEPTH))
                stk_d.cnt = stk_q.cnt + CW'(1);
        end else if (pop) begin
            // keep the last entry read when nothing is left below it
            if (stk_q.cnt == CW'(DEPTH))
                stk_d.top = stk_q.bot;
            if (stk_q.cnt != '0)
                stk_d.cnt = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign top_val = stk_q.top;
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import pcs_pkg::*;
#(
    parameter  int AW = PC_AW,
    parameter  int DW = PC_DW,
    localparam int PW = AW - DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          skip,
    input  logic          alu_wr,
    input  logic [DW-1:0] alu_data,
    input  logic          jmp_short,
    input  logic          call_short,
    input  logic          jmp_long,
    input  logic          call_long,
    input  logic          ret,
    input  logic [AW-1:0] imm_field,
    input  logic [PW-1:0] page_sel,
    output logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] pc_low
);
    localparam logic [AW-1:0] RESET_PC = '1;

    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_state_t;

    pc_state_t     st_d, st_q;
    pc_src_e       src;
    logic [AW-1:0] stk_top;
    logic [AW-1:0] pc_nxt;
    logic [AW-1:0] link_addr;
    logic          do_push;
    logic          do_pop;

    pcs_src_sel u_sel (
        .adv        (adv),
        .skip       (skip),
        .alu_wr     (alu_wr),
        .jmp_short  (jmp_short),
        .call_short (call_short),
        .jmp_long   (jmp_long),
        .call_long  (call_long),
        .ret        (ret),
        .src        (src)
    );

    pcs_addr_mux #(.AW(AW), .DW(DW)) u_mux (
        .src       (src),
        .pc_cur    (st_q.pc),
        .stk_top   (stk_top),
        .imm_field (imm_field),
        .alu_data  (alu_data),
        .page_sel  (page_sel),
        .pc_nxt    (pc_nxt)
    );

    always_comb begin
        link_addr = st_q.pc + AW'(1);
        do_push   = (src == SRC_CALL_S) || (src == SRC_CALL_L);
        do_pop    = (src == SRC_RET);
        st_d      = st_q;
        st_d.pc   = pc_nxt;
    end

    pcs_ret_stack #(.AW(AW)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (link_addr),
        .top_val  (stk_top)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = st_q.pc;
    assign pc_low     = st_q.pc[DW-1:0];
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter  int AW = 11,
    parameter  int DW = 8,
    localparam int PW = AW - DW - 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv,
    input logic          skip,
    input logic          alu_wr,
    input logic [DW-1:0] alu_data,
    input logic          jmp_short,
    input logic          call_short,
    input logic          jmp_long,
    input logic          call_long,
    input logic          ret,
    input logic [AW-1:0] imm_field,
    input logic [PW-1:0] page_sel,
    input logic [AW-1:0] fetch_addr,
    input logic [DW-1:0] pc_low
);
    logic any_xfer;
    assign any_xfer = ret | call_long | jmp_long | call_short | jmp_short | alu_wr;

    // R1
    p_reset_pc_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> fetch_addr == {AW{1'b1}});

    // R2
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_xfer && !skip && !adv) |=> $stable(fetch_addr));

    // R2
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_xfer && !skip && adv) |=> fetch_addr == $past(fetch_addr) + AW'(1));

    // R3
    p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_xfer && skip) |=> fetch_addr == $past(fetch_addr) + AW'(2));

    // R4
    p_alu_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_wr && !ret && !call_long && !jmp_long && !call_short && !jmp_short)
        |=> fetch_addr == {$past(page_sel), 1'b0, $past(alu_data)});

    // R5
    p_short_jmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_short && !ret && !call_long && !jmp_long && !call_short)
        |=> fetch_addr[AW-1:DW+1] == $past(page_sel));

    // R7
    p_long_jmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_long && !ret) |=> fetch_addr == $past(imm_field));

    // R8
    p_call_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((call_long && !ret) ##1 ret) |=> fetch_addr == $past(fetch_addr, 2) + AW'(1));

    // R11
    p_low_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pc_low == fetch_addr[DW-1:0]);
endmodule

bind paged_pc_unit pcs_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .skip       (skip),
    .alu_wr     (alu_wr),
    .alu_data   (alu_data),
    .jmp_short  (jmp_short),
    .call_short (call_short),
    .jmp_long   (jmp_long),
    .call_long  (call_long),
    .ret        (ret),
    .imm_field  (imm_field),
    .page_sel   (page_sel),
    .fetch_addr (fetch_addr),
    .pc_low     (pc_low)
);

// File: tb/tb_paged_pc_unit.sv
module tb_paged_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0, skip = 1'b0, alu_wr = 1'b0;
    logic [7:0]  alu_data = '0;
    logic        jmp_short = 1'b0, call_short = 1'b0, jmp_long = 1'b0, call_long = 1'b0, ret = 1'b0;
    logic [10:0] imm_field = '0;
    logic [1:0]  page_sel = '0;
    logic [10:0] fetch_addr;
    logic [7:0]  pc_low;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    paged_pc_unit dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .skip(skip), .alu_wr(alu_wr),
        .alu_data(alu_data), .jmp_short(jmp_short), .call_short(call_short),
        .jmp_long(jmp_long), .call_long(call_long), .ret(ret),
        .imm_field(imm_field), .page_sel(page_sel),
        .fetch_addr(fetch_addr), .pc_low(pc_low)
    );

    typedef struct packed {
        logic        a, s, w, js, cs, jl, cl, rt;
        logic [1:0]  pg;
        logic [7:0]  alu;
        logic [10:0] imm;
        logic [10:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    // a s w js cs jl cl rt  pg  alu    imm      exp     req
    localparam vec_t VECS [NV] = '{
        '{1,0,0,0,0,0,0,0, 2'd0, 8'h00, 11'h000, 11'h000, 4'd2 },  // R2 wrap 7FF->000
        '{1,0,0,0,0,0,0,0, 2'd0, 8'h00, 11'h000, 11'h001, 4'd2 },  // R2 step
        '{0,1,0,0,0,0,0,0, 2'd0, 8'h00, 11'h000, 11'h003, 4'd3 },  // R3 skip
        '{0,0,0,0,0,0,0,0, 2'd3, 8'hFF, 11'h7FF, 11'h003, 4'd2 },  // R2 hold
        '{0,0,0,1,0,0,0,0, 2'd1, 8'h00, 11'h1A5, 11'h3A5, 4'd5 },  // R5 short jump
        '{0,0,0,0,1,0,0,0, 2'd2, 8'h00, 11'h7C3, 11'h4C3, 4'd6 },  // R6 short call, push 3A6
        '{0,0,0,0,0,0,1,0, 2'd0, 8'h00, 11'h123, 11'h123, 4'd7 },  // R7 long call, push 4C4
        '{0,0,0,0,0,0,1,0, 2'd0, 8'h00, 11'h055, 11'h055, 4'd9 },  // R9 push on full, push 124
        '{0,0,0,0,0,0,0,1, 2'd0, 8'h00, 11'h000, 11'h124, 4'd8 },  // R8 pop newest
        '{0,0,0,0,0,0,0,1, 2'd0, 8'h00, 11'h000, 11'h4C4, 4'd9 },  // R9 3A6 was dropped
        '{0,0,0,0,0,0,0,1, 2'd0, 8'h00, 11'h000, 11'h4C4, 4'd10},  // R10 empty pop
        '{0,0,1,0,0,0,0,0, 2'd3, 8'h9E, 11'h000, 11'h69E, 4'd4 },  // R4 alu write
        '{0,0,0,0,0,1,0,0, 2'd0, 8'h00, 11'h7FE, 11'h7FE, 4'd7 },  // R7 long jump
        '{0,1,0,0,0,0,0,0, 2'd0, 8'h00, 11'h000, 11'h000, 4'd3 },  // R3 skip wraps
        '{1,0,1,0,0,0,0,0, 2'd0, 8'h37, 11'h000, 11'h037, 4'd12},  // R12 alu over advance
        '{1,0,0,0,0,1,0,1, 2'd0, 8'h00, 11'h100, 11'h4C4, 4'd12},  // R12 return over long jump
        '{0,0,0,1,1,0,0,0, 2'd0, 8'h00, 11'h011, 11'h011, 4'd12},  // R12 call over jump, push 4C5
        '{1,1,0,0,0,0,0,0, 2'd0, 8'h00, 11'h000, 11'h013, 4'd3 },  // R3 skip over advance
        '{0,0,0,0,0,0,0,1, 2'd0, 8'h00, 11'h000, 11'h4C5, 4'd8 }   // R8 return to link
    };

    task automatic check_pc(input logic [10:0] exp, input string tag);
        n_chk++;
        if (fetch_addr !== exp) begin
            n_fail++;
            $display("FAIL %s fetch_addr actual=%h expected=%h", tag, fetch_addr, exp);
        end
        n_chk++;
        if (pc_low !== exp[7:0]) begin
            n_fail++;
            $display("FAIL R11 (%s) pc_low actual=%h expected=%h", tag, pc_low, exp[7:0]);
        end
    endtask

    task automatic drive_idle();
        adv = 0; skip = 0; alu_wr = 0; jmp_short = 0; call_short = 0;
        jmp_long = 0; call_long = 0; ret = 0; alu_data = '0; imm_field = '0; page_sel = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_pc(11'h7FF, "R1 reset value");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            adv = VECS[i].a; skip = VECS[i].s; alu_wr = VECS[i].w;
            jmp_short = VECS[i].js; call_short = VECS[i].cs;
            jmp_long = VECS[i].jl; call_long = VECS[i].cl; ret = VECS[i].rt;
            page_sel = VECS[i].pg; alu_data = VECS[i].alu; imm_field = VECS[i].imm;
            @(posedge clk);
            #1;
            check_pc(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R1: reset mid-run restores 0x7FF and empties the stack
        @(negedge clk);
        drive_idle();
        call_long = 1; imm_field = 11'h2AA;
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        @(posedge clk); #1;
        check_pc(11'h7FF, "R1 reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        ret = 1;
        @(posedge clk); #1;
        check_pc(11'h000, "R1 return after reset");

        // R2: advance across a page boundary
        @(negedge clk);
        drive_idle();
        jmp_long = 1; imm_field = 11'h1FF;
        @(posedge clk); #1;
        check_pc(11'h1FF, "R7 long jump to page end");
        @(negedge clk);
        drive_idle();
        adv = 1;
        @(posedge clk); #1;
        check_pc(11'h200, "R2 cross page");

        // R6/R8: short call near top of space, return links past it
        @(negedge clk);
        drive_idle();
        call_short = 1; page_sel = 2'd3; imm_field = 11'h1FF;
        @(posedge clk); #1;
        check_pc(11'h6FF, "R6 short call page 3");
        @(negedge clk);
        drive_idle();
        ret = 1;
        @(posedge clk); #1;
        check_pc(11'h201, "R8 return from short call");

        @(negedge clk);
        drive_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule